// File: doc/BRIEF.md
# Port Input Change-Detect Interrupt

This block watches sixteen port inputs, grouped into two banks of eight, and raises an interrupt flag whenever a port set up as an input holds a level that differs from the snapshot stored for its bank. The flag shows only the present mismatch. It drops by itself once the pins return to their stored levels. Nothing latches an edge.

Software takes a fresh snapshot of one bank when it reads that bank's input register, or of both banks when it writes the configuration register. Either action also acknowledges any pending change. One clock edge after reset is released, all pins are captured, so a board with stable pins starts with the flag low. Ports configured as outputs play no part in the comparison. The snapshot still records their pin level, because the input register reports every pin whatever its direction. If a port is switched from output to input while its level differs from the snapshot, the flag rises at once. This is intended behaviour.

Top module: `chg_detect_irq`

## Requirements
- R1: When a port with direction bit 1 (input) differs from its bank's snapshot, `irq_flag` is 1 after the next rising clock edge.
- R2: A pulse on `rd_bank[b]` copies the eight pins of bank b (bank 0 = ports 7..0, bank 1 = ports 15..8) into that bank's snapshot at the next edge. The other bank's snapshot is left unchanged.
- R3: A pulse on `cfg_wr` copies all sixteen pins into both snapshots at the same edge.
- R4: A port with direction bit 0 (output) never affects `irq_flag`.
- R5: While reset is asserted, `snap` and `irq_flag` are 0. The first edge after release captures all pins into `snap`, and `irq_flag` stays 0 after that edge.
- R6: `irq_flag` returns to 0 one edge after every changed input is back at its snapshot level. No read is needed.
- R7: A bank that is being loaded contributes no mismatch at that edge, so a read with stable pins clears the flag at the same edge. A mismatch in the other bank keeps the flag at 1.
- R8: Changing a port's direction bit from 0 to 1 while its pin differs from the snapshot sets `irq_flag` after the next edge.
- R9: A snapshot load captures the pin levels of output-direction ports as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 16 | Synchronized pin levels, bit n = port n |
| port_is_in | input | 16 | Direction per port, 1 = input |
| rd_bank | input | 2 | Input-register read strobe per bank |
| cfg_wr | input | 1 | Configuration-register write strobe |
| snap | output | 16 | Stored snapshot, bank 1 in bits 15..8 |
| irq_flag | output | 1 | Registered change-detect interrupt flag |

## Verification
Both results settle one clock edge after their cause. A snapshot load appears on `snap`, and a mismatch or its removal appears on `irq_flag`, after the edge that follows the stimulus. The reset-release capture also shows after the first edge. The driver applies each stimulus just after a falling edge and queues the values expected for the next rising edge. The monitor compares them a short delay after that rising edge, so every check samples exactly one register stage after its stimulus.

// File: rtl/chg_pkg.sv
package chg_pkg;
  typedef enum logic {ST_INIT = 1'b0, ST_RUN = 1'b1} init_st_e;
endpackage

// File: rtl/chg_init_seq.sv
module chg_init_seq
  import chg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  output logic init_load
);
  init_st_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_INIT;
    else        st_q <= ST_RUN;
  end

  assign init_load = (st_q == ST_INIT);

  // R5: the start-up capture happens on exactly one edge
  a_r5_init_once: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |=> !init_load);
endmodule

// File: rtl/chg_bank.sv
module chg_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] dir_in,
  output logic [W-1:0] snap_q,
  output logic [W-1:0] mis
);
  function automatic logic [W-1:0] masked_diff(input logic [W-1:0] live,
                                               input logic [W-1:0] held,
                                               input logic [W-1:0] keep);
    return (live ^ held) & keep;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    snap_q <= '0;
    else if (load) snap_q <= pins;
  end

  assign mis = masked_diff(pins, snap_q, dir_in);

  // R2 / R9: a load captures every pin of the bank, whatever its direction
  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> snap_q == $past(pins));
  // R2: without a load the snapshot holds
  a_r2_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(snap_q));
endmodule

// File: rtl/chg_flag_reg.sv
module chg_flag_reg #(
  parameter int NB = 2,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB*W-1:0] mis_all,
  input  logic [NB-1:0] load_vec,
  input  logic          init_load,
  output logic          irq_q
);
  logic [NB-1:0] bank_hit;
  logic          irq_d;

  for (genvar b = 0; b < NB; b++) begin : g_hit
    assign bank_hit[b] = (|mis_all[b*W +: W]) && !load_vec[b];
  end

  assign irq_d = (|bank_hit) && !init_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R5: no flag after the start-up capture
  a_r5_quiet_init: assert property (@(posedge clk) disable iff (!rst_n)
    init_load |=> !irq_q);
endmodule

// File: rtl/chg_detect_irq.sv
module chg_detect_irq #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 8,
  localparam int PORT_W   = NUM_BANKS * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pin_lvl,
  input  logic [PORT_W-1:0] port_is_in,
  input  logic [NUM_BANKS-1:0] rd_bank,
  input  logic              cfg_wr,
  output logic [PORT_W-1:0] snap,
  output logic              irq_flag
);
  logic                 init_load;
  logic [NUM_BANKS-1:0] load_vec;
  logic [PORT_W-1:0]    mis_all;

  chg_init_seq u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_load (init_load)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign load_vec[b] = init_load | rd_bank[b] | cfg_wr;

    chg_bank #(.W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_vec[b]),
      .pins   (pin_lvl[b*BANK_W +: BANK_W]),
      .dir_in (port_is_in[b*BANK_W +: BANK_W]),
      .snap_q (snap[b*BANK_W +: BANK_W]),
      .mis    (mis_all[b*BANK_W +: BANK_W])
    );
  end

  chg_flag_reg #(.NB(NUM_BANKS), .W(BANK_W)) u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .mis_all   (mis_all),
    .load_vec  (load_vec),
    .init_load (init_load),
    .irq_q     (irq_flag)
  );

  // R1 / R6: with no load pending, the flag follows the masked mismatch one edge later
  a_r1_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_load && load_vec == '0) |=> irq_flag == $past(|mis_all));
  // R3: a configuration write refreshes every bank at one edge
  a_r3_cfg_both: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> snap == $past(pin_lvl));
  // R4: a mismatch confined to output ports never raises the flag
  a_r4_out_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    ((((pin_lvl ^ snap) & port_is_in) == '0) && !init_load) |=> !irq_flag);
endmodule

// File: tb/chg_detect_irq_tb_top.sv
`timescale 1ns/100ps
module chg_detect_irq_tb_top;
  typedef struct {
    logic [15:0] snap;
    logic        irq;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pin_lvl = '0;
  logic [15:0] port_is_in = 16'hFFFF;
  logic [1:0]  rd_bank = '0;
  logic        cfg_wr = 1'b0;
  logic [15:0] snap;
  logic        irq_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];
  logic [15:0] m_snap = '0;

  always #2.5 clk = ~clk;

  chg_detect_irq dut_i (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .port_is_in(port_is_in),
    .rd_bank(rd_bank), .cfg_wr(cfg_wr), .snap(snap), .irq_flag(irq_flag)
  );

  task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s snap actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push what the next edge must show
  task automatic step(input logic [15:0] p, input logic [15:0] d,
                      input logic [1:0] rd, input logic cfg,
                      input bit init, input string tag);
    exp_t e;
    @(negedge clk);
    pin_lvl = p; port_is_in = d; rd_bank = rd; cfg_wr = cfg;
    if (init) rst_n = 1'b1;
    if (init || cfg || rd[0]) m_snap[7:0]  = p[7:0];
    if (init || cfg || rd[1]) m_snap[15:8] = p[15:8];
    e.snap = m_snap;
    e.irq  = init ? 1'b0 : (|((p ^ m_snap) & d));
    e.tag  = tag;
    q.push_back(e);
  endtask

  // monitor: compare one rising edge after each stimulus
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check16(e.tag, snap, e.snap);
        check1(e.tag, irq_flag, e.irq);
      end
    end
  end

  initial begin
    #(20000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pin_lvl = 16'hA55A;
    repeat (2) @(posedge clk);
    #1;
    check16("R5 reset", snap, 16'h0000);
    check1("R5 reset", irq_flag, 1'b0);
    step(16'hA55A, 16'hFFFF, 2'b00, 1'b0, 1, "R5 init capture");
    step(16'hA55A, 16'hFFFF, 2'b00, 1'b0, 0, "R5 stable idle");
    step(16'hA55B, 16'hFFFF, 2'b00, 1'b0, 0, "R1 bank0 change");
    step(16'hA55A, 16'hFFFF, 2'b00, 1'b0, 0, "R6 self clear");
    step(16'hA75A, 16'hFFFF, 2'b00, 1'b0, 0, "R1 bank1 change");
    step(16'hA75A, 16'hFFFF, 2'b00, 1'b0, 0, "R1 bank1 held");
    step(16'hA75A, 16'hFFFF, 2'b10, 1'b0, 0, "R7 R2 read bank1 clears");
    step(16'hA752, 16'hFF00, 2'b00, 1'b0, 0, "R4 output change ignored");
    step(16'hA752, 16'hFF00, 2'b01, 1'b0, 0, "R9 read captures output pin");
    step(16'hA75A, 16'hFF00, 2'b00, 1'b0, 0, "R4 output change back ignored");
    step(16'hA75A, 16'hFFFF, 2'b00, 1'b0, 0, "R8 output to input mismatch");
    step(16'hA75A, 16'hFFFF, 2'b00, 1'b1, 0, "R3 cfg write resamples");
    step(16'hFF00, 16'hFFFF, 2'b00, 1'b0, 0, "R1 both banks change");
    step(16'hFF00, 16'hFFFF, 2'b00, 1'b1, 0, "R3 cfg loads both banks");
    step(16'h0F01, 16'hFFFF, 2'b00, 1'b0, 0, "R1 two bank mismatch");
    step(16'h0F01, 16'hFFFF, 2'b01, 1'b0, 0, "R7 R2 read bank0 other pending");
    step(16'h0F01, 16'hFFFF, 2'b10, 1'b0, 0, "R2 read bank1 clears");
    step(16'h0F01, 16'hFFFF, 2'b00, 1'b0, 0, "R6 stays clear");
    step(16'h0F01, 16'hFFFF, 2'b00, 1'b0, 0, "R6 idle");
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule